// File: doc/BRIEF.md
# Aligned byte stream word packer

This block turns a sequence of primitive values into a packed stream of 32-bit words under aligned serialization rules. Each value arrives as one input item carrying the value, a size code (1, 2, 4 or 8 bytes) and an alignment code. Before the value's bytes go out, the block inserts zero bytes until the running byte offset satisfies the requested alignment. It then writes the value most significant byte first. Only big-endian order is produced.

The block writes one byte per clock cycle into a word accumulator. A finished word is held back until either another byte arrives or the packet is closed, so that the final word of a packet can carry a last-word flag. A flush item closes the packet. It emits any partly filled word with its unused lanes at zero and restarts the offset at zero for the next packet. An input item stays presented (`in_valid` high, fields stable) until `in_ready` is high for one cycle, which marks the cycle in which the item is consumed.

Top module: `aligned_word_packer`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is low, and `in_ready` is low while `in_valid` is low.
- R2: Alignment code a (0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: 8 bytes) is met when the low a bits of the running offset are zero. Until then the block writes zero bytes, and these advance the offset.
- R3: Size code s gives 2^s bytes, taken from the low 2^s bytes of `in_data` and written most significant byte first. Higher bytes of `in_data` have no effect.
- R4: Offset bits 1..0 select the byte lane of the current word. Lane 0 is bits 31:24 of `out_data` and lane 3 is bits 7:0. Writing lane 3 completes a word.
- R5: The running offset is 3 bits wide and wraps modulo 8. Every written byte advances it, padding included. It is zero at the start of every packet, so a value after a flush is aligned from the packet start.
- R6: A flush with offset bits 1..0 not zero emits the partial word with its unused lanes zero. `in_data`, `in_size` and `in_align` are ignored on a flush item.
- R7: `out_last` is high on the final word of a packet and low on every other word. A flush of an empty packet emits no word. A flush is consumed in one cycle when the output register is free.
- R8: While `out_valid` is high and `out_ready` low, `out_data` and `out_last` hold. While a completed word is waiting and the output register is blocked, `in_ready` stays low. No byte is lost or duplicated.
- R9: The block writes at most one byte per cycle. With the output never blocked, a value that needs p padding bytes and has n bytes is consumed in the (p+n)-th cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input item is presented |
| in_flush | input | 1 | The item closes the packet instead of carrying a value |
| in_data | input | 64 | Value, right-justified |
| in_size | input | 2 | Size code: value has 2^code bytes |
| in_align | input | 2 | Alignment code: offset must be a multiple of 2^code |
| in_ready | output | 1 | High in the cycle the presented item is consumed |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Packed word, lane 0 in the top byte |
| out_last | output | 1 | Word is the final word of its packet |

## Verification
The hardest case to reach is the stall: a completed word sits in the holding register while the output register is also full and blocked, and the next byte arrives. The bench holds `out_ready` low across a whole 8-byte value so that one word moves into the output register and a second one fills the holding register. It then presents one more byte and watches `in_ready` stay low over several cycles before it releases the output. Padding of up to seven bytes is reached by starting an 8-byte value at offset 1. A long run of mixed sizes and alignments under irregular backpressure then checks every word and last flag against a model.

// File: rtl/awp_pkg.sv
package awp_pkg;
   localparam int OCTET_W = 8;
   typedef logic [OCTET_W-1:0] octet_t;
endpackage

// File: rtl/awp_pad_ctrl.sv
// Decides, for the current cycle, whether a padding byte or a data byte
// is written, and selects the data byte (most significant first).
module awp_pad_ctrl
   import awp_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int OFF_W  = 3,
   parameter int SIZE_W = 2,
   localparam int NBYTES = DATA_W / OCTET_W
) (
   input  logic [OFF_W-1:0]  offset,
   input  logic [SIZE_W-1:0] align_code,
   input  logic [SIZE_W-1:0] size_code,
   input  logic              data_phase,
   input  logic [OFF_W-1:0]  byte_idx,
   input  logic [DATA_W-1:0] value,
   output logic              is_pad,
   output logic              last_data,
   output octet_t            byte_o
);
   logic [OFF_W-1:0] align_mask;
   logic             aligned;
   logic [OFF_W:0]   nbytes;
   logic [OFF_W:0]   top_idx;
   logic [OFF_W-1:0] pos;
   octet_t           lanes [NBYTES];

   // offset bit g must be clear when the alignment asks for more than 2^g
   for (genvar g = 0; g < OFF_W; g++) begin : g_mask
      assign align_mask[g] = (32'(g) < 32'(align_code));
   end

   for (genvar k = 0; k < NBYTES; k++) begin : g_lanes
      assign lanes[k] = value[k*OCTET_W +: OCTET_W];
   end

   assign aligned   = ~|(offset & align_mask);
   assign nbytes    = (OFF_W+1)'(1) << size_code;
   assign top_idx   = nbytes - (OFF_W+1)'(1);
   assign last_data = ({1'b0, byte_idx} == top_idx);
   assign pos       = top_idx[OFF_W-1:0] - byte_idx;
   assign is_pad    = !data_phase && !aligned;
   assign byte_o    = is_pad ? '0 : lanes[pos];
endmodule

// File: rtl/awp_word_asm.sv
// Byte lane accumulator plus a one-word holding register, so that the
// final word of a packet is known before it leaves.
module awp_word_asm
   import awp_pkg::*;
#(
   parameter int WORD_BYTES = 4,
   localparam int WORD_W = WORD_BYTES * OCTET_W,
   localparam int LANE_W = $clog2(WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  octet_t            wr_byte,
   input  logic [LANE_W-1:0] lane,
   input  logic              flush_en,
   output logic              push,
   output logic [WORD_W-1:0] push_data,
   output logic              push_last,
   output logic              pend_valid
);
   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] pend_q;
   logic              pend_v_q;
   logic [WORD_W-1:0] merged;
   logic              lane_last;
   logic              partial;
   logic              byte_push;
   logic              flush_push;

   for (genvar l = 0; l < WORD_BYTES; l++) begin : g_merge
      assign merged[WORD_W-1-l*OCTET_W -: OCTET_W] =
         (lane == LANE_W'(l)) ? wr_byte : acc_q[WORD_W-1-l*OCTET_W -: OCTET_W];
   end

   assign lane_last  = (lane == LANE_W'(WORD_BYTES-1));
   assign partial    = (lane != '0);
   assign byte_push  = wr_en && pend_v_q;
   assign flush_push = flush_en && (pend_v_q || partial);
   assign push       = byte_push || flush_push;
   assign push_data  = pend_v_q ? pend_q : acc_q;
   assign push_last  = flush_en;
   assign pend_valid = pend_v_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         pend_q   <= '0;
         pend_v_q <= 1'b0;
      end else if (flush_en) begin
         acc_q    <= '0;
         pend_v_q <= 1'b0;
      end else if (wr_en) begin
         if (lane_last) begin
            acc_q    <= '0;
            pend_q   <= merged;
            pend_v_q <= 1'b1;
         end else begin
            acc_q    <= merged;
            pend_v_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/awp_out_stage.sv
// Single output register with valid/ready.
module awp_out_stage #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_data,
   input  logic              push_last,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              out_last,
   output logic              slot_free
);
   assign slot_free = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_last  <= 1'b0;
      end else if (push) begin
         out_valid <= 1'b1;
         out_data  <= push_data;
         out_last  <= push_last;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/aligned_word_packer.sv
module aligned_word_packer
   import awp_pkg::*;
#(
   parameter int WORD_BYTES = 4,
   parameter int MAX_BYTES  = 8,
   localparam int WORD_W = WORD_BYTES * OCTET_W,
   localparam int DATA_W = MAX_BYTES * OCTET_W,
   localparam int LANE_W = $clog2(WORD_BYTES),
   localparam int OFF_W  = $clog2(MAX_BYTES),
   localparam int SIZE_W = $clog2(OFF_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_flush,
   input  logic [DATA_W-1:0] in_data,
   input  logic [SIZE_W-1:0] in_size,
   input  logic [SIZE_W-1:0] in_align,
   output logic              in_ready,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              out_last
);
   if (WORD_BYTES < 2 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("WORD_BYTES must be a power of two, at least 2");
   end
   if (MAX_BYTES < WORD_BYTES || (MAX_BYTES & (MAX_BYTES - 1)) != 0) begin : g_bad_max
      $error("MAX_BYTES must be a power of two, at least WORD_BYTES");
   end

   logic [OFF_W-1:0]  offset_q;
   logic              data_phase_q;
   logic [OFF_W-1:0]  byte_idx_q;
   logic [LANE_W-1:0] lane;
   logic              is_pad;
   logic              last_data;
   octet_t            wr_byte;
   logic              pend_valid;
   logic              slot_free;
   logic              byte_req;
   logic              wr_en;
   logic              flush_needs_slot;
   logic              flush_en;
   logic              data_done;
   logic              push;
   logic [WORD_W-1:0] push_data;
   logic              push_last;

   assign lane = offset_q[LANE_W-1:0];

   awp_pad_ctrl #(
      .DATA_W (DATA_W),
      .OFF_W  (OFF_W),
      .SIZE_W (SIZE_W)
   ) u_pad (
      .offset     (offset_q),
      .align_code (in_align),
      .size_code  (in_size),
      .data_phase (data_phase_q),
      .byte_idx   (byte_idx_q),
      .value      (in_data),
      .is_pad     (is_pad),
      .last_data  (last_data),
      .byte_o     (wr_byte)
   );

   // a byte may go in unless it would displace a held word into a full output
   assign byte_req         = in_valid && !in_flush;
   assign wr_en            = byte_req && (!pend_valid || slot_free);
   assign flush_needs_slot = pend_valid || (lane != '0);
   assign flush_en         = in_valid && in_flush && (!flush_needs_slot || slot_free);
   assign data_done        = wr_en && !is_pad && last_data;
   assign in_ready         = flush_en || data_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offset_q     <= '0;
         data_phase_q <= 1'b0;
         byte_idx_q   <= '0;
      end else if (flush_en) begin
         offset_q     <= '0;
         data_phase_q <= 1'b0;
         byte_idx_q   <= '0;
      end else if (wr_en) begin
         offset_q <= offset_q + OFF_W'(1);
         if (!is_pad) begin
            if (last_data) begin
               data_phase_q <= 1'b0;
               byte_idx_q   <= '0;
            end else begin
               data_phase_q <= 1'b1;
               byte_idx_q   <= byte_idx_q + OFF_W'(1);
            end
         end
      end
   end

   awp_word_asm #(
      .WORD_BYTES (WORD_BYTES)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_byte    (wr_byte),
      .lane       (lane),
      .flush_en   (flush_en),
      .push       (push),
      .push_data  (push_data),
      .push_last  (push_last),
      .pend_valid (pend_valid)
   );

   awp_out_stage #(
      .WORD_W (WORD_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .push_last (push_last),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_last  (out_last),
      .slot_free (slot_free)
   );
endmodule

// File: rtl/awp_checker.sv
module awp_checker #(
   parameter int WORD_W = 32,
   parameter int OFF_W  = 3,
   parameter int LANE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_flush,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_data,
   input logic              out_last,
   input logic [OFF_W-1:0]  offset,
   input logic              pend_valid
);
   a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

   a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid && out_valid && !out_ready && in_valid |-> !in_ready);

   a_r5_flush_restarts_offset: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_flush && in_ready |=> offset == '0);

   a_r9_one_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_flush) |=> (offset == $past(offset)) || (offset == $past(offset) + OFF_W'(1)));

   a_r6_flush_partial_last: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_flush && in_ready && (offset[LANE_W-1:0] != '0) |=> out_valid && out_last);

   a_r7_empty_flush_silent: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_flush && in_ready && (offset == '0) && !pend_valid && !out_valid |=> !out_valid);
endmodule

bind aligned_word_packer awp_checker #(
   .WORD_W (WORD_W),
   .OFF_W  (OFF_W),
   .LANE_W (LANE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_flush   (in_flush),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .out_last   (out_last),
   .offset     (offset_q),
   .pend_valid (pend_valid)
);

// File: tb/aligned_word_packer_test.sv
module aligned_word_packer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_flush = 1'b0;
   logic [63:0] in_data = '0;
   logic [1:0]  in_size = '0;
   logic [1:0]  in_align = '0;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;
   logic        out_last;

   int checks = 0;
   int fails = 0;
   bit finished = 0;
   bit force_low = 0;
   bit bp_on = 0;

   logic [32:0] exp_q[$];
   logic [32:0] mon_exp;
   logic [32:0] mon_seen = '0;
   int          m_off = 0;
   logic [7:0]  m_word[4];
   bit          m_pend_v = 0;
   logic [31:0] m_pend = '0;

   always #5 clk = ~clk;

   aligned_word_packer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flush(in_flush),
      .in_data(in_data), .in_size(in_size), .in_align(in_align), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
   );

   always @(posedge clk)
      out_ready <= force_low ? 1'b0 : (bp_on ? (($urandom % 3) != 0) : 1'b1);

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected word", {31'b0, out_last, out_data}, 64'h0);
         end else begin
            mon_exp = exp_q.pop_front();
            check({out_last, out_data} == mon_exp, "R3 R4 R7 word", {31'b0, out_last, out_data}, {31'b0, mon_exp});
         end
         mon_seen = {out_last, out_data};
      end
   end

   // model of the packing rules
   function automatic void m_put(input logic [7:0] b);
      int lane = m_off % 4;
      if (m_pend_v && lane == 0) begin
         exp_q.push_back({1'b0, m_pend});
         m_pend_v = 0;
      end
      m_word[lane] = b;
      if (lane == 3) begin
         m_pend = {m_word[0], m_word[1], m_word[2], m_word[3]};
         m_pend_v = 1;
         for (int i = 0; i < 4; i++) m_word[i] = 8'h00;
      end
      m_off = (m_off + 1) % 8;
   endfunction

   function automatic int m_value(input logic [63:0] d, input int sz, input int al);
      int n = 1 << sz;
      int am = (1 << al) - 1;
      int pads = 0;
      while ((m_off & am) != 0) begin
         m_put(8'h00);
         pads++;
      end
      for (int i = n - 1; i >= 0; i--) m_put(d[8*i +: 8]);
      return pads;
   endfunction

   function automatic void m_flush();
      if (m_pend_v) exp_q.push_back({1'b1, m_pend});
      else if (m_off % 4 != 0) exp_q.push_back({1'b1, m_word[0], m_word[1], m_word[2], m_word[3]});
      m_pend_v = 0;
      m_off = 0;
      for (int i = 0; i < 4; i++) m_word[i] = 8'h00;
   endfunction

   // called at a falling edge with the item already driven
   task automatic wait_acc(output int cyc);
      cyc = 0;
      forever begin
         #1;
         cyc++;
         if (in_ready) break;
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_flush = 1'b0;
   endtask

   task automatic send(input logic [63:0] d, input int sz, input int al, output int pads, output int cyc);
      pads = m_value(d, sz, al);
      in_valid = 1'b1;
      in_flush = 1'b0;
      in_data  = d;
      in_size  = sz[1:0];
      in_align = al[1:0];
      wait_acc(cyc);
   endtask

   task automatic flush(output int cyc);
      m_flush();
      in_valid = 1'b1;
      in_flush = 1'b1;
      in_data  = {$urandom, $urandom};
      in_size  = 2'($urandom);
      in_align = 2'($urandom);
      wait_acc(cyc);
   endtask

   task automatic drain();
      int n = 0;
      while ((exp_q.size() != 0 || out_valid) && n < 500) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      int p, c;
      for (int i = 0; i < 4; i++) m_word[i] = 8'h00;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", {63'b0, out_valid}, 64'h0);
      check(in_ready == 1'b0, "R1 in_ready in reset", {63'b0, in_ready}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && in_ready == 1'b0, "R1 idle after reset", {62'b0, out_valid, in_ready}, 64'h0);

      // R2 R4 R6: A1, one pad, then 1234 -> word A1001234 marked last
      send(64'hDEAD_BEEF_CAFE_00A1, 0, 0, p, c);
      check(c == 1, "R9 one byte value", c, 1);
      send(64'hFFFF_FFFF_FFFF_1234, 1, 1, p, c);
      check(p == 1 && c == 3, "R2 pad before 2-byte value", c, 3);
      flush(c);
      check(c == 1, "R7 flush one cycle", c, 1);
      drain();
      check(mon_seen == 33'h1_A100_1234, "R4 lane order and pad", {31'b0, mon_seen}, 64'h1_A100_1234);

      // R6: partial word zero-filled (bytes 5A 6B then flush)
      send(64'h0000_0000_0000_005A, 0, 0, p, c);
      send(64'h0000_0000_0000_006B, 0, 0, p, c);
      flush(c);
      drain();
      check(mon_seen == 33'h1_5A6B_0000, "R6 partial flush", {31'b0, mon_seen}, 64'h1_5A6B_0000);

      // R3 R9: mixed sizes, garbage in upper bytes, long padding
      send(64'h0000_0000_0000_0011, 0, 0, p, c);
      send(64'hFFFF_FFFF_1122_3344, 2, 2, p, c);
      check(p == 3 && c == 7, "R9 4-byte value after 3 pads", c, 7);
      send(64'h0102_0304_0506_0708, 3, 3, p, c);
      check(p == 0 && c == 8, "R9 8-byte value aligned", c, 8);
      send(64'h0000_0000_0000_0055, 0, 0, p, c);
      send(64'h8877_6655_4433_2211, 3, 3, p, c);
      check(p == 7 && c == 15, "R2 seven pads before 8-byte value", c, 15);
      send(64'hAAAA_AAAA_AAAA_BEEF, 1, 1, p, c);
      send(64'h0000_0000_0000_0077, 0, 2, p, c);
      flush(c);
      drain();

      // R5: offset restarts after a flush at an odd offset
      send(64'h01, 0, 0, p, c);
      send(64'h02, 0, 0, p, c);
      send(64'h03, 0, 0, p, c);
      flush(c);
      send(64'h0000_0000_C0DE_F00D, 2, 2, p, c);
      check(c == 4, "R5 no pad at packet start", c, 4);
      flush(c);
      drain();

      // R7: empty packet
      flush(c);
      check(c == 1, "R7 empty flush one cycle", c, 1);
      repeat (5) @(negedge clk);
      check(out_valid == 1'b0, "R7 empty packet emits nothing", {63'b0, out_valid}, 64'h0);

      // R8: stall with a held word and a blocked output register
      force_low = 1;
      repeat (2) @(negedge clk);
      send(64'h1111_2222_3333_4444, 3, 3, p, c);
      check(c == 8, "R8 8 bytes fit before stall", c, 8);
      void'(m_value(64'h99, 0, 0));
      in_valid = 1'b1;
      in_flush = 1'b0;
      in_data  = 64'h99;
      in_size  = 2'd0;
      in_align = 2'd0;
      repeat (8) begin
         #1;
         check(in_ready == 1'b0 && out_valid == 1'b1, "R8 input held while blocked", {62'b0, in_ready, out_valid}, 64'h1);
         @(negedge clk);
      end
      force_low = 0;
      wait_acc(c);
      flush(c);
      drain();

      // mixed traffic under backpressure
      bp_on = 1;
      for (int k = 0; k < 40; k++) begin
         int nv = 1 + ($urandom % 6);
         for (int j = 0; j < nv; j++)
            send({$urandom, $urandom}, $urandom % 4, $urandom % 4, p, c);
         flush(c);
      end
      bp_on = 0;
      drain();
      check(exp_q.size() == 0, "R8 no word lost or duplicated", exp_q.size(), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule